// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit generates the address stream for a multi-register load or store. A one-cycle start pulse loads a base address, a register-select mask, one of four walk modes and a flag that says whether the base register is to be rewritten. The unit then emits one beat for each set bit of the mask. Each beat carries a word address and the index of the register that belongs to it. Each beat is held until the memory side accepts it.

The address window always sits on one side of the base. Which side it is on, and whether the base word itself falls inside the window, depends on the mode. Within the window the walk always goes upward: the lowest selected register index takes the lowest address. After the final beat is accepted, a one-cycle completion pulse presents the updated base value. It also presents a qualifier that tells the register file whether to write that value back. A stack push or pop maps onto one of the modes. A full-descending push uses mode 3 and its pop uses mode 0. A full-ascending push uses mode 1 and its pop uses mode 2. Moving the data and holding the registers are left to the neighbouring logic.

Top module: `blkxfer_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, beat_valid_o, done_o, wb_en_o and busy_o are all 0.
- R2: With N bits set in the mask and base B, the first beat address depends on the 2-bit mode code. Code 0 gives B. Code 1 gives B+4. Code 2 gives B-4N+4. Code 3 gives B-4N. All arithmetic wraps modulo 2^32.
- R3: Each beat after the first is 4 above the address of the beat accepted before it. The first beat appears in the cycle after the start pulse.
- R4: Beats carry the selected register indices in strictly ascending order. Each set bit of the mask is visited exactly once, and no clear bit is visited.
- R5: While beat_valid_o is 1 and beat_ready_i is 0, the beat address and index hold steady. A beat is consumed only in a cycle where both are 1.
- R6: done_o is 1 for exactly one cycle, in the cycle after the last beat is accepted. It is never 1 together with beat_valid_o.
- R7: When done_o is 1, wb_base_o equals B+4N for codes 0 and 1 and equals B-4N for codes 2 and 3. wb_en_o equals the writeback flag captured at start, and it is 0 whenever done_o is 0.
- R8: An all-zero mask produces no beats. done_o is 1 in the cycle after the start pulse, and wb_base_o equals the base unchanged.
- R9: A start pulse is ignored unless busy_o is 0. This applies during beats and during the done cycle.
- R10: Base bits [1:0] are ignored and treated as zero, so every beat address has bits [1:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| base_i | input | 32 | Base address sampled with start_i |
| list_i | input | 16 | Register-select mask, bit i selects register i |
| mode_i | input | 2 | Walk mode: 0 up-after, 1 up-before, 2 down-after, 3 down-before |
| wb_i | input | 1 | Request to rewrite the base at completion |
| beat_valid_o | output | 1 | A beat is presented |
| beat_ready_i | input | 1 | Memory side accepts the current beat |
| beat_addr_o | output | 32 | Word address of the current beat |
| beat_reg_o | output | 4 | Register index of the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Write the updated base back (valid with done_o) |
| wb_base_o | output | 32 | Updated base value |
| busy_o | output | 1 | Transfer in progress or completing |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while a stalled transfer is still running, carrying a different mask and mode. The bench handles it by holding beat_ready_i low for stretches of a long transfer and pulsing start_i with conflicting fields in those cycles. It then confirms that the beat count and the addresses still follow the first request. Completion on an empty mask and a descending window that wraps below address zero are also reached on purpose, using base 0 with a full mask.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [1:0] {
      XM_UP_AFTER    = 2'd0,
      XM_UP_BEFORE   = 2'd1,
      XM_DOWN_AFTER  = 2'd2,
      XM_DOWN_BEFORE = 2'd3
   } xfer_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
   parameter int LIST_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic [LIST_W-1:0] list_i,
   output logic [CNT_W-1:0]  count_o
);

   if (CNT_W < $clog2(LIST_W + 1)) begin : g_bad_cnt
      $error("blkxfer_popcnt: CNT_W too narrow for LIST_W");
   end

   always_comb begin
      count_o = '0;
      for (int i = 0; i < LIST_W; i++) begin
         count_o = count_o + CNT_W'(list_i[i]);
      end
   end

endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
   parameter int LIST_W = 16,
   parameter int IDX_W  = 4
) (
   input  logic [LIST_W-1:0] mask_i,
   output logic [LIST_W-1:0] onehot_o,
   output logic [IDX_W-1:0]  idx_o
);

   if (IDX_W < $clog2(LIST_W)) begin : g_bad_idx
      $error("blkxfer_lowbit: IDX_W too narrow for LIST_W");
   end

   // isolate the least significant set bit
   assign onehot_o = mask_i & (~mask_i + LIST_W'(1));

   // encode: each index bit is the OR of the one-hot lines whose index has it set
   for (genvar b = 0; b < IDX_W; b++) begin : g_enc
      logic [LIST_W-1:0] sel;
      for (genvar i = 0; i < LIST_W; i++) begin : g_sel
         assign sel[i] = ((i >> b) & 1) != 0;
      end
      assign idx_o[b] = |(onehot_o & sel);
   end

endmodule

// File: rtl/blkxfer_bounds.sv
module blkxfer_bounds
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   input  xfer_mode_e        mode_i,
   output logic [ADDR_W-1:0] first_o,
   output logic [ADDR_W-1:0] wb_o
);

   localparam int ALIGN_W = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(WORD_BYTES - 1);

   if ((1 << ALIGN_W) != WORD_BYTES) begin : g_bad_word
      $error("blkxfer_bounds: WORD_BYTES must be a power of two");
   end

   logic [ADDR_W-1:0] base_al;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] top_up;
   logic [ADDR_W-1:0] bot_down;

   assign base_al  = base_i & ~LOW_MASK;
   assign span     = ADDR_W'(count_i) << ALIGN_W;
   assign top_up   = base_al + span;
   assign bot_down = base_al - span;

   always_comb begin
      unique case (mode_i)
         XM_UP_AFTER:    first_o = base_al;
         XM_UP_BEFORE:   first_o = base_al + STEP;
         XM_DOWN_AFTER:  first_o = bot_down + STEP;
         default:        first_o = bot_down;
      endcase
      wb_o = mode_i[1] ? bot_down : top_up;
   end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIST_W     = 16,
   parameter int WORD_BYTES = 4,
   localparam int IDX_W     = $clog2(LIST_W),
   localparam int CNT_W     = $clog2(LIST_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [LIST_W-1:0] list_i,
   input  logic [1:0]        mode_i,
   input  logic              wb_i,
   output logic              beat_valid_o,
   input  logic              beat_ready_i,
   output logic [ADDR_W-1:0] beat_addr_o,
   output logic [IDX_W-1:0]  beat_reg_o,
   output logic              done_o,
   output logic              wb_en_o,
   output logic [ADDR_W-1:0] wb_base_o,
   output logic              busy_o
);

   localparam int ALIGN_W = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if (LIST_W < 2) begin : g_bad_list
      $error("blkxfer_seq: LIST_W must be at least 2");
   end
   if (ADDR_W <= ALIGN_W + CNT_W) begin : g_bad_addr
      $error("blkxfer_seq: ADDR_W too narrow for the transfer span");
   end

   seq_state_e        state_q;
   logic [LIST_W-1:0] mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] wbval_q;
   logic              wbflag_q;

   logic [CNT_W-1:0]  n_sel;
   logic [ADDR_W-1:0] first_addr;
   logic [ADDR_W-1:0] wb_calc;
   logic [LIST_W-1:0] pick_oh;
   logic [IDX_W-1:0]  pick_idx;
   logic [LIST_W-1:0] mask_rest;
   logic              accept;

   blkxfer_popcnt #(.LIST_W(LIST_W), .CNT_W(CNT_W)) u_count (
      .list_i  (list_i),
      .count_o (n_sel)
   );

   blkxfer_bounds #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_bounds (
      .base_i  (base_i),
      .count_i (n_sel),
      .mode_i  (xfer_mode_e'(mode_i)),
      .first_o (first_addr),
      .wb_o    (wb_calc)
   );

   blkxfer_lowbit #(.LIST_W(LIST_W), .IDX_W(IDX_W)) u_pick (
      .mask_i   (mask_q),
      .onehot_o (pick_oh),
      .idx_o    (pick_idx)
   );

   assign mask_rest = mask_q & ~pick_oh;
   assign accept    = (state_q == SQ_RUN) && beat_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         mask_q   <= '0;
         addr_q   <= '0;
         wbval_q  <= '0;
         wbflag_q <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  mask_q   <= list_i;
                  addr_q   <= first_addr;
                  wbval_q  <= wb_calc;
                  wbflag_q <= wb_i;
                  state_q  <= (list_i == '0) ? SQ_DONE : SQ_RUN;
               end
            end
            SQ_RUN: begin
               if (accept) begin
                  mask_q <= mask_rest;
                  addr_q <= addr_q + STEP;
                  if (mask_rest == '0) state_q <= SQ_DONE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign beat_valid_o = (state_q == SQ_RUN);
   assign beat_addr_o  = addr_q;
   assign beat_reg_o   = pick_idx;
   assign done_o       = (state_q == SQ_DONE);
   assign wb_en_o      = done_o && wbflag_q;
   assign wb_base_o    = wbval_q;
   assign busy_o       = (state_q != SQ_IDLE);

   // R5: a stalled beat holds address and index
   a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o)));

   // R3: consecutive beats step by one word
   a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && beat_ready_i) |=> (!beat_valid_o || beat_addr_o == $past(beat_addr_o) + STEP));

   // R4: indices strictly rise from beat to beat
   a_r4_index_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && beat_ready_i) |=> (!beat_valid_o || beat_reg_o > $past(beat_reg_o)));

   // R4: the presented index is pending and no lower index is pending
   a_r4_lowest_pending: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid_o |-> (mask_q[beat_reg_o] && ((mask_q << (LIST_W - int'(beat_reg_o))) == '0)));

   // R10: every beat address is word aligned
   a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid_o |-> (beat_addr_o[ALIGN_W-1:0] == '0));

   // R6: completion is a single-cycle pulse, exclusive with beats
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && beat_valid_o));

   // R7: writeback qualifier only with completion
   a_r7_wb_qual: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> done_o);

   // R9: a start while a stalled beat waits changes nothing
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid_o && !beat_ready_i && start_i) |=> ($stable(mask_q) && $stable(wbval_q) && $stable(addr_q)));

endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_i = '0;
   logic [15:0] list_i = '0;
   logic [1:0]  mode_i = '0;
   logic        wb_i = 1'b0;
   logic        beat_ready_i = 1'b0;
   logic        beat_valid_o;
   logic [31:0] beat_addr_o;
   logic [3:0]  beat_reg_o;
   logic        done_o;
   logic        wb_en_o;
   logic [31:0] wb_base_o;
   logic        busy_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   blkxfer_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .base_i       (base_i),
      .list_i       (list_i),
      .mode_i       (mode_i),
      .wb_i         (wb_i),
      .beat_valid_o (beat_valid_o),
      .beat_ready_i (beat_ready_i),
      .beat_addr_o  (beat_addr_o),
      .beat_reg_o   (beat_reg_o),
      .done_o       (done_o),
      .wb_en_o      (wb_en_o),
      .wb_base_o    (wb_base_o),
      .busy_o       (busy_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_state = 0;        // 0 idle, 1 beats, 2 done
   int unsigned m_addr[$];
   int          m_reg[$];
   int unsigned m_wb = 0;
   bit          m_wbf = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0;
         m_addr.delete();
         m_reg.delete();
         m_wb = 0;
         m_wbf = 0;
      end else begin
         case (m_state)
            0: if (start_i) begin
               int n;
               int unsigned b;
               int unsigned first;
               n = 0;
               for (int i = 0; i < 16; i++) if (list_i[i]) n++;
               b = base_i & 32'hFFFF_FFFC;
               case (mode_i)
                  2'd0: first = b;
                  2'd1: first = b + 4;
                  2'd2: first = b - 4*n + 4;
                  default: first = b - 4*n;
               endcase
               m_wb  = mode_i[1] ? b - 4*n : b + 4*n;
               m_wbf = wb_i;
               m_addr.delete();
               m_reg.delete();
               for (int i = 0; i < 16; i++) begin
                  if (list_i[i]) begin
                     m_addr.push_back(first);
                     m_reg.push_back(i);
                     first = first + 4;
                  end
               end
               m_state = (n == 0) ? 2 : 1;
            end
            1: if (beat_ready_i) begin
               void'(m_addr.pop_front());
               void'(m_reg.pop_front());
               if (m_addr.size() == 0) m_state = 2;
            end
            default: m_state = 0;
         endcase
      end
   end

   // compare outputs against the model away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(beat_valid_o == (m_state == 1), "R5", "beat_valid", beat_valid_o, m_state == 1);
         chk(done_o == (m_state == 2), "R6 R8", "done", done_o, m_state == 2);
         chk(busy_o == (m_state != 0), "R9", "busy", busy_o, m_state != 0);
         if (m_state == 1 && beat_valid_o) begin
            chk(beat_addr_o == m_addr[0], "R2 R3 R10", "beat_addr", beat_addr_o, m_addr[0]);
            chk(int'(beat_reg_o) == m_reg[0], "R4", "beat_reg", beat_reg_o, m_reg[0]);
         end
         if (m_state == 2) begin
            chk(wb_base_o == m_wb, "R7", "wb_base", wb_base_o, m_wb);
            chk(wb_en_o == m_wbf, "R7", "wb_en", wb_en_o, m_wbf);
         end else begin
            chk(wb_en_o == 1'b0, "R7", "wb_en idle", wb_en_o, 0);
         end
      end
   end

   // beat monitor (reads pre-update values at the edge)
   int          beats = 0;
   int unsigned first_seen = 0;
   int unsigned last_wb = 0;
   always @(posedge clk) begin
      if (beat_valid_o && beat_ready_i) begin
         if (beats == 0) first_seen = beat_addr_o;
         beats++;
      end
      if (done_o) last_wb = wb_base_o;
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic run_xfer(input logic [31:0] b, input logic [15:0] l,
                           input logic [1:0] m, input bit w,
                           input bit stall, input bit poke);
      int k;
      beats = 0;
      @(negedge clk);
      start_i = 1'b1; base_i = b; list_i = l; mode_i = m; wb_i = w;
      beat_ready_i = stall ? 1'b0 : 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      list_i = ~l; mode_i = ~m; base_i = b ^ 32'h0000_1000;
      k = 0;
      while (!done_o) begin
         beat_ready_i = stall ? (($urandom % 3) != 0) : 1'b1;
         start_i = poke && (k % 3 == 1);
         k++;
         @(negedge clk);
      end
      // done cycle: a start here must also be ignored
      start_i = poke;
      beat_ready_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!beat_valid_o && !done_o && !wb_en_o && !busy_o, "R1", "outputs in reset",
          {beat_valid_o, done_o, wb_en_o, busy_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!beat_valid_o && !done_o && !busy_o, "R1", "outputs after reset",
          {beat_valid_o, done_o, busy_o}, 0);

      // R2 R7: each mode on base 0x100, registers 1..3
      run_xfer(32'h100, 16'h000E, 2'd0, 1'b1, 1'b0, 1'b0);
      chk(first_seen == 32'h100, "R2", "up-after first", first_seen, 32'h100);
      chk(last_wb == 32'h10C, "R7", "up-after wb", last_wb, 32'h10C);
      chk(beats == 3, "R4", "beat count", beats, 3);
      run_xfer(32'h100, 16'h000E, 2'd1, 1'b1, 1'b0, 1'b0);
      chk(first_seen == 32'h104, "R2", "up-before first", first_seen, 32'h104);
      chk(last_wb == 32'h10C, "R7", "up-before wb", last_wb, 32'h10C);
      run_xfer(32'h100, 16'h000E, 2'd2, 1'b0, 1'b0, 1'b0);
      chk(first_seen == 32'hF8, "R2", "down-after first", first_seen, 32'hF8);
      chk(last_wb == 32'hF4, "R7", "down-after wb", last_wb, 32'hF4);
      run_xfer(32'h100, 16'h000E, 2'd3, 1'b1, 1'b0, 1'b0);
      chk(first_seen == 32'hF4, "R2", "down-before first", first_seen, 32'hF4);
      chk(last_wb == 32'hF4, "R7", "down-before wb", last_wb, 32'hF4);

      // R8: empty mask
      run_xfer(32'h400, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0);
      chk(beats == 0, "R8", "empty beat count", beats, 0);
      chk(last_wb == 32'h400, "R8", "empty wb", last_wb, 32'h400);

      // R10: misaligned base bits ignored
      run_xfer(32'h203, 16'h8001, 2'd0, 1'b1, 1'b1, 1'b0);
      chk(first_seen == 32'h200, "R10", "aligned first", first_seen, 32'h200);
      chk(last_wb == 32'h208, "R10", "aligned wb", last_wb, 32'h208);

      // R5 R3: full mask, down-before across zero, with stalls
      run_xfer(32'h0, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b0);
      chk(first_seen == 32'hFFFF_FFC0, "R3", "wrap first", first_seen, 32'hFFFF_FFC0);
      chk(beats == 16, "R5", "full beat count", beats, 16);

      // R9: conflicting starts during a stalled transfer and its done cycle
      run_xfer(32'h800, 16'h5A5A, 2'd1, 1'b1, 1'b1, 1'b1);
      chk(beats == 8, "R9", "beats unaffected by start", beats, 8);
      chk(last_wb == 32'h820, "R9", "wb unaffected by start", last_wb, 32'h820);
      @(negedge clk);
      chk(!busy_o, "R9", "idle after poked run", busy_o, 0);

      // R4: sparse and single-register masks
      run_xfer(32'h1000, 16'h8000, 2'd2, 1'b0, 1'b0, 1'b0);
      chk(first_seen == 32'h1000, "R4", "single high reg", first_seen, 32'h1000);
      for (int t = 0; t < 20; t++) begin
         run_xfer($urandom, 16'($urandom), 2'($urandom), 1'($urandom), 1'b1, 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule